// File: doc/BRIEF.md
# Reed-Solomon (255,223) Systematic Encoder

This block turns a stream of bytes, grouped into blocks of 223 data bytes, into 255-byte codewords. The data bytes are forwarded to the output unchanged and in the same cycle. Once the last data byte of a block has been accepted, the block appends 32 check bytes. The check bytes allow a downstream decoder to correct up to 16 corrupted bytes per codeword. Both sides are valid/ready byte streams. The input carries start-of-block and end-of-block markers, and the output carries its own markers framing the full 255-byte codeword.

The check bytes are computed in a 32-stage, byte-wide feedback shift register. It multiplies by the constant generator coefficients through shared logarithm and antilogarithm tables that are computed when the design is elaborated, so the datapath holds no general Galois-field multiplier. A block that is closed early, or that is cut short by a new start marker, raises a one-cycle error pulse. In that case no check bytes are emitted, and the register is cleared for the next block.

Top module: `rs_enc_223`

## Requirements
- R1: Arithmetic is in GF(2^8) with field polynomial 0x11D and primitive element 0x02. The 255 output bytes of a full block, read with the first byte as the coefficient of x^254, form a polynomial that is zero at alpha^i for every i from 0 to 31.
- R2: While data bytes are flowing, m_valid_o follows s_valid_i, m_data_o equals s_data_i and s_ready_o equals m_ready_i, all in the same cycle. Out of reset, with no input, m_valid_o is 0.
- R3: After the 223rd accepted data byte, exactly 32 check bytes follow. The first of them is the coefficient of x^31 of the remainder and the last is the coefficient of x^0. An all-zero block gives all-zero check bytes.
- R4: While check bytes are being emitted, s_ready_o is 0 and m_valid_o is 1.
- R5: m_sob_o is set on the first output byte of a block. m_eob_o is set on output byte 255 only, whether or not the input marked the 223rd byte with s_eob_i.
- R6: While m_ready_i is low during the check phase, m_data_o holds its value.
- R7: The register clears at the start of each block, so the check bytes depend only on the current block's data, including after a truncated block.
- R8: An input byte accepted with s_eob_i set before the 223rd byte gives a one-cycle err_o pulse in the following cycle. No check bytes are produced, and the next byte opens a new block.
- R9: An input byte accepted with s_sob_i set in the middle of a block restarts the block at that byte and gives a one-cycle err_o pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Input byte valid |
| s_data_i | input | 8 | Input data byte |
| s_sob_i | input | 1 | Input byte is first of a block |
| s_eob_i | input | 1 | Input byte is last of a block |
| s_ready_o | output | 1 | Encoder accepts an input byte |
| m_valid_o | output | 1 | Output byte valid |
| m_data_o | output | 8 | Output byte (data or check) |
| m_sob_o | output | 1 | Output byte is first of a codeword |
| m_eob_o | output | 1 | Output byte is byte 255 of a codeword |
| m_ready_i | input | 1 | Downstream accepts an output byte |
| err_o | output | 1 | Block cut short (one-cycle pulse) |

## Verification
Data bytes, the markers, s_ready_o and the R4 phase conditions are combinational, so the bench checks them in the same cycle the stimulus is driven, sampling at the falling edge. The first check byte is due one rising edge after the 223rd input byte is accepted. Each later check byte is due one edge after the previous one is taken, and the bench captures each output byte only on a falling edge where valid and ready are both high. err_o is registered and due one edge after the offending byte is accepted, so the bench counts pulses through the cycle after each block and compares the total against the expected count.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam int FIELD_SZ = 256;
  localparam logic [8:0] PRIM_POLY = 9'h11D;
  localparam logic [7:0] ALPHA = 8'h02;
  localparam int MAX_PAR = 64;

  typedef logic [SYM_W-1:0] sym_t;
  typedef sym_t [FIELD_SZ-1:0] tbl_t;
  typedef sym_t [MAX_PAR:0] poly_t;

  // elaboration-time only
  function automatic sym_t gf_mul_ref(sym_t a, sym_t b);
    sym_t p;
    logic [8:0] t;
    p = '0;
    t = {1'b0, a};
    for (int k = 0; k < SYM_W; k++) begin
      if (b[k]) p = p ^ t[7:0];
      t = {t[7:0], 1'b0};
      if (t[8]) t = t ^ PRIM_POLY;
    end
    return p;
  endfunction

  function automatic tbl_t build_exp();
    tbl_t e;
    e[0] = 8'h01;
    for (int i = 1; i < FIELD_SZ; i++) e[i] = gf_mul_ref(e[i-1], ALPHA);
    return e;
  endfunction

  function automatic tbl_t build_log();
    tbl_t e;
    tbl_t l;
    e = build_exp();
    l = '0;
    for (int i = 0; i < FIELD_SZ - 1; i++) l[e[i]] = sym_t'(i);
    return l;
  endfunction

  function automatic poly_t build_gen(int n);
    poly_t g;
    sym_t r;
    g = '0;
    g[0] = 8'h01;
    r = 8'h01;
    for (int i = 0; i < n; i++) begin
      for (int j = i + 1; j > 0; j--) g[j] = g[j-1] ^ gf_mul_ref(g[j], r);
      g[0] = gf_mul_ref(g[0], r);
      r = gf_mul_ref(r, ALPHA);
    end
    return g;
  endfunction

  localparam tbl_t EXP_T = build_exp();
  localparam tbl_t LOG_T = build_log();
endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
  import rs_enc_pkg::*;
#(
  parameter sym_t COEF = 8'h01
) (
  input  sym_t a_i,
  output sym_t p_o
);
  localparam logic [8:0] COEF_LOG = {1'b0, LOG_T[COEF]};

  logic [8:0] lsum;

  // log-domain add, modulo 255, then antilog
  always_comb begin
    lsum = {1'b0, LOG_T[a_i]} + COEF_LOG;
    if (lsum >= 9'd255) lsum = lsum - 9'd255;
    p_o = (a_i == '0 || COEF == '0) ? '0 : EXP_T[lsum[7:0]];
  end
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
  import rs_enc_pkg::*;
#(
  parameter int N_PAR = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clr_i,
  input  logic shift_i,
  input  sym_t din_i,
  output sym_t top_o
);
  localparam poly_t GEN = build_gen(N_PAR);

  sym_t [N_PAR-1:0] stage_q;
  sym_t [N_PAR-1:0] stage_d;
  sym_t [N_PAR-1:0] prod;
  sym_t fb;

  assign top_o = stage_q[N_PAR-1];
  assign fb = din_i ^ (clr_i ? '0 : top_o);

  for (genvar j = 0; j < N_PAR; j++) begin : g_tap
    rs_gf_cmul #(.COEF(GEN[j])) u_mul (.a_i(fb), .p_o(prod[j]));
  end

  always_comb begin
    stage_d = stage_q;
    if (load_i) begin
      stage_d[0] = prod[0];
      for (int j = 1; j < N_PAR; j++)
        stage_d[j] = (clr_i ? '0 : stage_q[j-1]) ^ prod[j];
    end else if (shift_i) begin
      stage_d[0] = '0;
      for (int j = 1; j < N_PAR; j++) stage_d[j] = stage_q[j-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  // R7: a zero byte opening a block leaves an empty register
  a_r7_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && clr_i && din_i == '0 |=> stage_q == '0);
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl #(
  parameter int N_DATA = 223,
  parameter int N_PAR  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_valid_i,
  input  logic s_sob_i,
  input  logic s_eob_i,
  input  logic m_ready_i,
  output logic s_ready_o,
  output logic par_o,
  output logic load_o,
  output logic clr_o,
  output logic shift_o,
  output logic m_sob_o,
  output logic m_eob_o,
  output logic err_o
);
  localparam int CW = $clog2(N_DATA);
  localparam int PW = $clog2(N_PAR);
  localparam logic [CW-1:0] LAST_D = CW'(N_DATA - 1);
  localparam logic [PW-1:0] LAST_P = PW'(N_PAR - 1);

  logic [CW-1:0] cnt_q, idx;
  logic [PW-1:0] pcnt_q;
  logic par_q, err_q;
  logic acc, first, short_blk, restart;

  assign s_ready_o = !par_q && m_ready_i;
  assign acc       = s_valid_i && s_ready_o;
  assign first     = (cnt_q == '0) || s_sob_i;
  assign idx       = first ? '0 : cnt_q;
  assign short_blk = s_eob_i && (idx != LAST_D);
  assign restart   = s_sob_i && (cnt_q != '0);

  assign par_o   = par_q;
  assign load_o  = acc;
  assign clr_o   = first;
  assign shift_o = par_q && m_ready_i;
  assign m_sob_o = !par_q && first;
  assign m_eob_o = par_q && (pcnt_q == LAST_P);
  assign err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
      par_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= acc && (short_blk || restart);
      if (acc) begin
        if (short_blk) begin
          cnt_q <= '0;
        end else if (idx == LAST_D) begin
          cnt_q  <= '0;
          par_q  <= 1'b1;
          pcnt_q <= '0;
        end else begin
          cnt_q <= idx + 1'b1;
        end
      end
      if (shift_o) begin
        pcnt_q <= pcnt_q + 1'b1;
        if (pcnt_q == LAST_P) par_q <= 1'b0;
      end
    end
  end

  a_r3_enter_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !short_blk && idx == LAST_D |=> par_q);

  a_r5_eob_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_eob_o && m_ready_i |=> !par_q);

  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(s_valid_i && s_ready_o && (s_eob_i || s_sob_i)));

  a_r4_no_intake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_q && !m_ready_i |=> par_q && !s_ready_o);
endmodule

// File: rtl/rs_enc_223.sv
module rs_enc_223 #(
  parameter int N_DATA = 223,
  parameter int N_PAR  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       s_valid_i,
  input  logic [7:0] s_data_i,
  input  logic       s_sob_i,
  input  logic       s_eob_i,
  output logic       s_ready_o,
  output logic       m_valid_o,
  output logic [7:0] m_data_o,
  output logic       m_sob_o,
  output logic       m_eob_o,
  input  logic       m_ready_i,
  output logic       err_o
);
  logic par, load, clr, shift;
  logic [7:0] top;

  rs_enc_ctrl #(.N_DATA(N_DATA), .N_PAR(N_PAR)) u_ctrl (
    .clk_i, .rst_ni, .s_valid_i, .s_sob_i, .s_eob_i, .m_ready_i,
    .s_ready_o, .par_o(par), .load_o(load), .clr_o(clr), .shift_o(shift),
    .m_sob_o, .m_eob_o, .err_o
  );

  rs_parity_lfsr #(.N_PAR(N_PAR)) u_lfsr (
    .clk_i, .rst_ni, .load_i(load), .clr_i(clr), .shift_i(shift),
    .din_i(s_data_i), .top_o(top)
  );

  assign m_valid_o = par ? 1'b1 : s_valid_i;
  assign m_data_o  = par ? top : s_data_i;

  a_r6_par_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par && !m_ready_i |=> $stable(m_data_o));
endmodule

// File: tb/test_rs_enc_223.sv
module test_rs_enc_223;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic s_valid_i = 1'b0, s_sob_i = 1'b0, s_eob_i = 1'b0, m_ready_i = 1'b1;
  logic [7:0] s_data_i = '0;
  logic s_ready_o, m_valid_o, m_sob_o, m_eob_o, err_o;
  logic [7:0] m_data_o;

  always #4 clk = ~clk;

  rs_enc_223 i_rs_enc_223 (
    .clk_i(clk), .rst_ni, .s_valid_i, .s_data_i, .s_sob_i, .s_eob_i, .s_ready_o,
    .m_valid_o, .m_data_o, .m_sob_o, .m_eob_o, .m_ready_i, .err_o
  );

  int n_chk = 0, n_fail = 0, errs = 0;
  bit done = 1'b0;
  logic [7:0] din [0:222];
  logic [7:0] ob [0:299];
  bit ob_sob [0:299];
  bit ob_eob [0:299];
  int oc;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = '0;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p = p ^ a;
      a = a[7] ? ((a << 1) ^ 8'h1D) : (a << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] synd(int i);
    logic [7:0] r = 8'h01;
    logic [7:0] s = '0;
    for (int t = 0; t < i; t++) r = gmul(r, 8'h02);
    for (int k = 0; k < 255; k++) s = gmul(s, r) ^ ob[k];
    return s;
  endfunction

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      s_valid_i = 1'b0; s_sob_i = 1'b0; s_eob_i = 1'b0; m_ready_i = 1'b1;
      @(negedge clk);
      if (err_o) errs++;
      @(posedge clk); #1;
    end
  endtask

  task automatic run_block(int len, bit sob, bit eob, int vprob, int rprob);
    int ic = 0, guard = 0, target;
    bit hold = 1'b0;
    logic [7:0] hb = '0;
    target = (len == 223) ? 255 : len;
    oc = 0;
    while ((ic < len || oc < target) && guard < 5000) begin
      s_valid_i = (ic < len) && (($urandom % 100) < vprob);
      s_data_i  = (ic < len) ? din[ic] : 8'h00;
      s_sob_i   = sob && (ic == 0);
      s_eob_i   = eob && (ic == len - 1);
      m_ready_i = (($urandom % 100) < rprob);
      @(negedge clk);
      if (hold) chk(m_data_o == hb, "R6 check byte held", m_data_o, hb);
      if (target == 255 && oc >= 223)
        chk(!s_ready_o && m_valid_o, "R4 check phase", {s_ready_o, m_valid_o}, 2'b01);
      else if (oc < 223)
        chk(m_valid_o == s_valid_i && s_ready_o == m_ready_i && (!m_valid_o || m_data_o == s_data_i),
            "R2 pass-through", m_data_o, s_data_i);
      if (m_valid_o && m_ready_i) begin
        ob[oc] = m_data_o; ob_sob[oc] = m_sob_o; ob_eob[oc] = m_eob_o;
        oc++;
      end
      hold = (target == 255 && oc >= 223 && oc < 255) && m_valid_o && !m_ready_i;
      hb = m_data_o;
      if (s_valid_i && s_ready_o) ic++;
      if (err_o) errs++;
      @(posedge clk); #1;
      guard++;
    end
    if (guard >= 5000) chk(1'b0, "watchdog block", guard, 0);
    idle(1);
  endtask

  task automatic check_full(string req);
    int ns = 0, ne = 0;
    bit dok = 1'b1;
    chk(oc == 255, "R3 codeword length", oc, 255);
    for (int k = 0; k < 223; k++) if (ob[k] != din[k]) dok = 1'b0;
    chk(dok, "R2 data unchanged", dok, 1);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] s = synd(i);
      chk(s == 8'h00, {req, " R1/R3 syndrome zero"}, s, 0);
    end
    for (int k = 0; k < 255; k++) begin ns += ob_sob[k]; ne += ob_eob[k]; end
    chk(ob_sob[0] && ns == 1, "R5 sob on first byte", ns, 1);
    chk(ob_eob[254] && ne == 1, "R5 eob on byte 255", ne, 1);
  endtask

  task automatic fill(int kind, int arg);
    for (int k = 0; k < 223; k++) begin
      case (kind)
        0: din[k] = 8'h00;
        1: din[k] = (k == arg) ? 8'(arg * 7 + 1) : 8'h00;
        2: din[k] = 8'(k + arg);
        3: din[k] = 8'($urandom);
        default: din[k] = 8'hFF;
      endcase
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog global", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int e0, ne;
    void'($urandom(17));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(m_valid_o == 1'b0, "R2 reset no output", m_valid_o, 0);
    chk(s_ready_o == 1'b1, "R2 reset ready", s_ready_o, 1);
    chk(err_o == 1'b0, "R8 reset no error", err_o, 0);
    @(posedge clk); #1;

    // R3: zero data gives zero check bytes
    fill(0, 0);
    run_block(223, 1, 1, 100, 100);
    check_full("R3 zero");
    for (int k = 223; k < 255; k++) chk(ob[k] == 8'h00, "R3 zero parity", ob[k], 0);

    // R1: impulse sweep over positions and values
    for (int p = 0; p < 223; p += 17) begin
      fill(1, p);
      run_block(223, 1, 1, 100, 100);
      check_full("R1 impulse");
    end
    fill(1, 222);
    run_block(223, 1, 0, 100, 100);
    check_full("R1 impulse last, no eob in");

    // R6: ramps and random data under stalls on both sides
    for (int s = 0; s < 6; s++) begin
      fill(2, s * 40);
      run_block(223, 1, 1, 70, 55);
      check_full("R6 ramp stalled");
    end
    for (int s = 0; s < 8; s++) begin
      fill(3, 0);
      run_block(223, (s % 2) == 0, 1, 80, 50);
      check_full("R1 random");
    end
    fill(4, 0);
    run_block(223, 1, 1, 100, 100);
    check_full("R1 all ones");

    // R8: early end-of-block
    e0 = errs;
    fill(3, 0);
    run_block(50, 1, 1, 90, 90);
    ne = 0;
    for (int k = 0; k < oc; k++) ne += ob_eob[k];
    chk(oc == 50 && ne == 0, "R8 no check bytes, no eob", oc, 50);
    chk(errs - e0 == 1, "R8 error pulse", errs - e0, 1);
    fill(3, 0);
    run_block(223, 1, 1, 90, 80);
    check_full("R7 after truncated");

    e0 = errs;
    fill(2, 3);
    run_block(1, 1, 1, 100, 100);
    chk(errs - e0 == 1, "R8 one-byte block error", errs - e0, 1);

    // R9: restart by start marker mid-block
    e0 = errs;
    fill(4, 0);
    run_block(30, 1, 0, 100, 100);
    chk(errs - e0 == 0, "R9 no error before restart", errs - e0, 0);
    fill(3, 0);
    run_block(223, 1, 1, 100, 100);
    chk(errs - e0 == 1, "R9 restart error pulse", errs - e0, 1);
    check_full("R7/R9 block after restart");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule